// File: doc/BRIEF.md
# Dynamic Bus Sizing Read Sequencer

This block takes one read request at a time from a 64-bit internal port and carries it out on a narrow external bus. The external data path is 8, 16 or 32 bits wide, as set by a configuration input. An access can be a byte, half-word, word or double-word, or it can be a burst beat. When the access is wider than the configured bus, the block breaks it into several external sub-cycles. These are issued from the lowest address upward, and each one advances by one bus-width unit.

The external address bus has only 20 lines, so every sub-cycle runs in three clock phases. The first phase presents the upper part of the scaled address on the top eight lines. The second phase presents the lower 20 bits of the scaled address. The third phase is the data phase, in which the returned data is sampled. The address is scaled by the bus width: it is shifted right by 0, 1 or 2 bits, so a wider bus reaches a larger space. Each returned unit is written into the byte lanes of a 64-bit read word that match its address offset. The block then reports completion with a one-cycle pulse.

The controller is a five-state machine:
- IDLE: waiting. On an accepted request it goes to ADDR_HI.
- ADDR_HI: always goes to ADDR_LO.
- ADDR_LO: always goes to XFER.
- XFER: goes back to ADDR_HI while sub-cycles remain. After the last one it goes to DONE.
- DONE: always returns to IDLE.

Top module: `bsz_seq`

## Requirements
- R1: `bus_width` encodes the external width as 0 for 8 bits, 1 for 16 bits and 2 for 32 bits, and the value 3 behaves as 32 bits. Only the low 1, 2 or 4 bytes of `ext_rdata` are used, and the remaining lanes have no effect on `rd_data`.
- R2: `req_size` encodes 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. The number of sub-cycles is the larger of 1 and (access bytes / bus bytes), so an 8-byte access takes 8, 4 or 2 sub-cycles on an 8, 16 or 32-bit bus.
- R3: With `req_burst` set, the access is treated as 8 bytes whatever `req_size` says.
- R4: The first sub-cycle addresses the request address rounded down to the larger of the access size and the bus width. Each later sub-cycle addresses the next bus-width unit above it.
- R5: Each sub-cycle raises `ext_phase_hi`, `ext_phase_lo` and `ext_phase_data` in three consecutive cycles, with at most one of them high at a time.
- R6: In the lower phase, `ext_addr` equals physical address bits [19+k:k], where k is 0, 1 or 2 for 8, 16 or 32-bit mode.
- R7: In the upper phase, `ext_addr[19:12]` equals physical address bits [27+k:20+k] and `ext_addr[11:0]` is zero. Outside the address phases `ext_addr` is zero.
- R8: The data sampled at the end of a data phase for unit address a is placed in `rd_data` starting at byte lane a[2:0]. Lanes that no sub-cycle of the access wrote read as zero.
- R9: `busy` is high, and `req_ready` low, from the cycle after acceptance through the last data phase. Requests presented while the block is busy are ignored.
- R10: `done` is a single-cycle pulse in the cycle after the last data phase. `rd_data` is valid then and holds its value until the next request is accepted.
- R11: After reset the block is idle: `req_ready` is 1, and `busy`, `done`, every phase strobe, `ext_addr` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle; a request is accepted this cycle |
| req_addr | input | 32 | Physical byte address of the access |
| req_size | input | 2 | Access size code |
| req_burst | input | 1 | Burst beat; forces a full 8-byte access |
| bus_width | input | 2 | External data width code |
| busy | output | 1 | Sub-cycles outstanding |
| ext_addr | output | 20 | Multiplexed external address |
| ext_phase_hi | output | 1 | Upper address phase strobe |
| ext_phase_lo | output | 1 | Lower address phase strobe |
| ext_phase_data | output | 1 | Data phase strobe; `ext_rdata` is sampled at its end |
| ext_rdata | input | 32 | External read data lanes |
| done | output | 1 | Access complete pulse |
| rd_data | output | 64 | Assembled read word |

## Verification
The assertions assume that `bus_width` stays constant while an access is in progress, because a change in the middle of an access would break the rule that the lower address rises by one scaled unit per sub-cycle. The bench changes the width only while the block is idle, just before it presents a request. The assertions also assume that `ext_rdata` is driven during each data phase. The bench's memory model drives it from the lower phase onward, and it puts a filler pattern on the lanes above the configured width.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR_HI = 3'd1,
        ST_ADDR_LO = 3'd2,
        ST_XFER    = 3'd3,
        ST_DONE    = 3'd4
    } state_e;

    typedef enum logic [1:0] {
        BW_8    = 2'd0,
        BW_16   = 2'd1,
        BW_32   = 2'd2,
        BW_RSVD = 2'd3
    } bw_e;

    // log2 of the external unit in bytes; the reserved code acts as 32 bits
    function automatic logic [1:0] unit_log2(input logic [1:0] bw);
        logic [1:0] r;
        unique case (bw)
            BW_8:    r = 2'd0;
            BW_16:   r = 2'd1;
            default: r = 2'd2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bsz_plan.sv
module bsz_plan
    import bsz_pkg::*;
#(
    parameter int PADDR_W = 32,
    parameter int CNT_W   = 4
) (
    input  logic [PADDR_W-1:0] addr,
    input  logic [1:0]         size,
    input  logic               burst,
    input  logic [1:0]         bw,
    output logic [CNT_W-1:0]   count,
    output logic [PADDR_W-1:0] base,
    output logic [1:0]         ul2
);

    logic [1:0] sz_l2;
    logic [1:0] span_l2;

    always_comb begin
        ul2     = unit_log2(bw);
        sz_l2   = burst ? 2'd3 : size;
        span_l2 = (sz_l2 > ul2) ? sz_l2 : ul2;
        count   = CNT_W'(1) << (span_l2 - ul2);
        base    = addr & ~((PADDR_W'(1) << span_l2) - PADDR_W'(1));
    end

endmodule

// File: rtl/bsz_addr_fmt.sv
module bsz_addr_fmt #(
    parameter int PADDR_W = 32,
    parameter int EXT_AW  = 20,
    parameter int UPPER_W = 8
) (
    input  logic [PADDR_W-1:0] cur_addr,
    input  logic [1:0]         ul2,
    input  logic               sel_hi,
    input  logic               sel_lo,
    output logic [EXT_AW-1:0]  ext_addr
);

    localparam int LOW_ZERO = EXT_AW - UPPER_W;

    logic [EXT_AW-1:0]  lower;
    logic [UPPER_W-1:0] upper;

    always_comb begin
        lower = EXT_AW'(cur_addr >> ul2);
        upper = UPPER_W'(cur_addr >> (32'(ul2) + 32'(EXT_AW)));
        if (sel_hi) begin
            ext_addr = {upper, {LOW_ZERO{1'b0}}};
        end else if (sel_lo) begin
            ext_addr = lower;
        end else begin
            ext_addr = '0;
        end
    end

endmodule

// File: rtl/bsz_pack.sv
module bsz_pack #(
    parameter int EXT_DW = 32,
    parameter int INT_DW = 64,
    localparam int OFF_W = $clog2(INT_DW / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [OFF_W-1:0]  lane_off,
    input  logic [1:0]        ul2,
    input  logic [EXT_DW-1:0] ext_rdata,
    output logic [INT_DW-1:0] rd_data
);

    localparam int EXT_BYTES = EXT_DW / 8;
    localparam int INT_BYTES = INT_DW / 8;
    localparam int EIDX_W    = $clog2(EXT_BYTES);

    logic [7:0]     ext_b [EXT_BYTES];
    logic [OFF_W:0] unit_bytes;

    assign unit_bytes = (OFF_W + 1)'(1) << ul2;

    generate
        for (genvar e = 0; e < EXT_BYTES; e++) begin : g_ext
            assign ext_b[e] = ext_rdata[e*8 +: 8];
        end

        for (genvar b = 0; b < INT_BYTES; b++) begin : g_lane
            logic [OFF_W:0] rel;
            logic           hit;
            logic [7:0]     q;

            always_comb begin
                rel = (OFF_W + 1)'(b) - {1'b0, lane_off};
                hit = capture && ({1'b0, lane_off} <= (OFF_W + 1)'(b))
                      && (rel < unit_bytes);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (clear) begin
                    q <= '0;
                end else if (hit) begin
                    q <= ext_b[rel[EIDX_W-1:0]];
                end
            end

            assign rd_data[b*8 +: 8] = q;
        end
    endgenerate

endmodule

// File: rtl/bsz_seq.sv
module bsz_seq
    import bsz_pkg::*;
#(
    parameter int PADDR_W = 32,
    parameter int EXT_AW  = 20,
    parameter int UPPER_W = 8,
    parameter int EXT_DW  = 32,
    parameter int INT_DW  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [PADDR_W-1:0] req_addr,
    input  logic [1:0]         req_size,
    input  logic               req_burst,
    input  logic [1:0]         bus_width,
    output logic               busy,
    output logic [EXT_AW-1:0]  ext_addr,
    output logic               ext_phase_hi,
    output logic               ext_phase_lo,
    output logic               ext_phase_data,
    input  logic [EXT_DW-1:0]  ext_rdata,
    output logic               done,
    output logic [INT_DW-1:0]  rd_data
);

    localparam int INT_BYTES = INT_DW / 8;
    localparam int OFF_W     = $clog2(INT_BYTES);
    localparam int CNT_W     = OFF_W + 1;

    state_e              state_q;
    state_e              state_d;
    logic [PADDR_W-1:0]  cur_addr;
    logic [CNT_W-1:0]    remain;
    logic [1:0]          ul2_q;
    logic                accept;
    logic                last_unit;

    logic [CNT_W-1:0]    plan_count;
    logic [PADDR_W-1:0]  plan_base;
    logic [1:0]          plan_ul2;

    bsz_plan #(
        .PADDR_W (PADDR_W),
        .CNT_W   (CNT_W)
    ) i_plan (
        .addr  (req_addr),
        .size  (req_size),
        .burst (req_burst),
        .bw    (bus_width),
        .count (plan_count),
        .base  (plan_base),
        .ul2   (plan_ul2)
    );

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign last_unit = (remain == CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_ADDR_HI;
            ST_ADDR_HI: state_d = ST_ADDR_LO;
            ST_ADDR_LO: state_d = ST_XFER;
            ST_XFER:    state_d = last_unit ? ST_DONE : ST_ADDR_HI;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // sub-cycle bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
            ul2_q    <= '0;
        end else if (accept) begin
            cur_addr <= plan_base;
            remain   <= plan_count;
            ul2_q    <= plan_ul2;
        end else if (state_q == ST_XFER) begin
            cur_addr <= cur_addr + (PADDR_W'(1) << ul2_q);
            remain   <= remain - CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        req_ready      = 1'b0;
        busy           = 1'b0;
        ext_phase_hi   = 1'b0;
        ext_phase_lo   = 1'b0;
        ext_phase_data = 1'b0;
        done           = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_ADDR_HI: begin busy = 1'b1; ext_phase_hi = 1'b1; end
            ST_ADDR_LO: begin busy = 1'b1; ext_phase_lo = 1'b1; end
            ST_XFER:    begin busy = 1'b1; ext_phase_data = 1'b1; end
            ST_DONE:    done = 1'b1;
            default:    req_ready = 1'b0;
        endcase
    end

    bsz_addr_fmt #(
        .PADDR_W (PADDR_W),
        .EXT_AW  (EXT_AW),
        .UPPER_W (UPPER_W)
    ) i_addr_fmt (
        .cur_addr (cur_addr),
        .ul2      (ul2_q),
        .sel_hi   (ext_phase_hi),
        .sel_lo   (ext_phase_lo),
        .ext_addr (ext_addr)
    );

    bsz_pack #(
        .EXT_DW (EXT_DW),
        .INT_DW (INT_DW)
    ) i_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .capture   (ext_phase_data),
        .lane_off  (cur_addr[OFF_W-1:0]),
        .ul2       (ul2_q),
        .ext_rdata (ext_rdata),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/bsz_seq_chk.sv
module bsz_seq_chk #(
    parameter int EXT_AW  = 20,
    parameter int UPPER_W = 8,
    parameter int INT_DW  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              busy,
    input logic [EXT_AW-1:0] ext_addr,
    input logic              ext_phase_hi,
    input logic              ext_phase_lo,
    input logic              ext_phase_data,
    input logic              done
);

    localparam int MAX_SUB  = INT_DW / 8;
    localparam int LOW_ZERO = EXT_AW - UPPER_W;
    localparam int SC_W     = $clog2(MAX_SUB) + 2;

    logic [SC_W-1:0]   sub_cnt;
    logic              seen_lo;
    logic [EXT_AW-1:0] prev_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_cnt <= '0;
            seen_lo <= 1'b0;
            prev_lo <= '0;
        end else if (req_valid && req_ready) begin
            sub_cnt <= '0;
            seen_lo <= 1'b0;
        end else begin
            if (ext_phase_data) sub_cnt <= sub_cnt + SC_W'(1);
            if (ext_phase_lo) begin
                seen_lo <= 1'b1;
                prev_lo <= ext_addr;
            end
        end
    end

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_phase_hi, ext_phase_lo, ext_phase_data})); // R5
    AST_HI_THEN_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ext_phase_hi |=> ext_phase_lo); // R5
    AST_LO_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ext_phase_lo |=> ext_phase_data); // R5
    AST_UPPER_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ext_phase_hi |-> (ext_addr[LOW_ZERO-1:0] == '0)); // R7
    AST_LO_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_phase_lo && seen_lo) |-> (ext_addr == prev_lo + EXT_AW'(1))); // R4
    AST_SUBCYCLE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        sub_cnt <= SC_W'(MAX_SUB)); // R2
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(ext_phase_hi || ext_phase_lo || ext_phase_data)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ext_phase_data)); // R10

endmodule

bind bsz_seq bsz_seq_chk #(
    .EXT_AW  (EXT_AW),
    .UPPER_W (UPPER_W),
    .INT_DW  (INT_DW)
) i_bsz_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .busy           (busy),
    .ext_addr       (ext_addr),
    .ext_phase_hi   (ext_phase_hi),
    .ext_phase_lo   (ext_phase_lo),
    .ext_phase_data (ext_phase_data),
    .done           (done)
);

// File: tb/test_bsz_seq.sv
module test_bsz_seq;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_burst = 1'b0;
    logic [1:0]  bus_width = 2'd2;
    logic        busy;
    logic [19:0] ext_addr;
    logic        ext_phase_hi;
    logic        ext_phase_lo;
    logic        ext_phase_data;
    logic [31:0] ext_rdata = 32'hEEEE_EEEE;
    logic        done;
    logic [63:0] rd_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bsz_seq i_bsz_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .req_size       (req_size),
        .req_burst      (req_burst),
        .bus_width      (bus_width),
        .busy           (busy),
        .ext_addr       (ext_addr),
        .ext_phase_hi   (ext_phase_hi),
        .ext_phase_lo   (ext_phase_lo),
        .ext_phase_data (ext_phase_data),
        .ext_rdata      (ext_rdata),
        .done           (done),
        .rd_data        (rd_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cur_sh   = 2;

    logic [7:0]  q_hi [$];
    logic [19:0] q_lo [$];
    logic [63:0] q_data [$];
    int          q_cnt [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ {2'b00, a[29:24]} ^ 8'h3C;
    endfunction

    // external memory model: serves the unit named by the two address phases
    logic [7:0] seen_hi = '0;
    always @(negedge clk) begin
        logic [31:0] pa;
        if (ext_phase_hi) seen_hi = ext_addr[19:12];
        if (ext_phase_lo) begin
            pa = {4'b0, seen_hi, ext_addr} << cur_sh;
            ext_rdata = 32'hEEEE_EEEE;
            for (int j = 0; j < (1 << cur_sh); j++)
                ext_rdata[j*8 +: 8] = mem_byte(pa + 32'(j));
        end
    end

    // scoreboard monitor
    int sub_seen = 0;
    bit prev_done = 1'b0;
    always @(negedge clk) begin
        logic [7:0]  eh;
        logic [19:0] el;
        logic [63:0] ed;
        int          ec;
        if (rst_n) begin
            if (ext_phase_hi) begin
                if (q_hi.size() == 0) begin
                    check(1'b0, "R9", "unexpected upper phase", 64'(ext_addr), 64'(0));
                end else begin
                    eh = q_hi.pop_front();
                    check(ext_addr == {eh, 12'h000}, "R7", "upper address",
                          64'(ext_addr), 64'({eh, 12'h000}));
                end
            end
            if (ext_phase_lo) begin
                if (q_lo.size() == 0) begin
                    check(1'b0, "R9", "unexpected lower phase", 64'(ext_addr), 64'(0));
                end else begin
                    el = q_lo.pop_front();
                    check(ext_addr == el, "R6", "lower address (R4 order)",
                          64'(ext_addr), 64'(el));
                end
            end
            if (ext_phase_hi || ext_phase_lo || ext_phase_data)
                check(busy && !req_ready, "R9", "busy during sub-cycle",
                      64'({busy, req_ready}), 64'(2'b10));
            if (ext_phase_data) sub_seen++;
            if (done) begin
                check(!prev_done, "R10", "done longer than one cycle", 64'(1), 64'(0));
                if (q_data.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", 64'(1), 64'(0));
                end else begin
                    ed = q_data.pop_front();
                    ec = q_cnt.pop_front();
                    check(rd_data == ed, "R8", "assembled read data (R1 lanes)", rd_data, ed);
                    check(sub_seen == ec, "R2", "sub-cycle count (R3 burst)",
                          64'(sub_seen), 64'(ec));
                end
                sub_seen = 0;
            end
            prev_done = done;
        end
    end

    task automatic run_access(input logic [31:0] addr, input logic [1:0] size,
                              input bit burst, input logic [1:0] mode, input bit poke);
        int sh, w, s, span, n;
        logic [31:0] base, a;
        logic [63:0] exp;
        sh   = (mode == 2'd0) ? 0 : (mode == 2'd1) ? 1 : 2;
        w    = 1 << sh;
        s    = burst ? 8 : (1 << size);
        span = (s > w) ? s : w;
        n    = span / w;
        base = addr & ~(32'(span) - 32'd1);
        exp  = '0;
        for (int i = 0; i < n; i++) begin
            a = base + 32'(i * w);
            q_hi.push_back(8'(a >> (sh + 20)));
            q_lo.push_back(20'(a >> sh));
            for (int j = 0; j < w; j++)
                exp[(32'(a[2:0]) + j)*8 +: 8] = mem_byte(a + 32'(j));
        end
        q_data.push_back(exp);
        q_cnt.push_back(n);

        @(negedge clk);
        bus_width = mode;
        cur_sh    = sh;
        req_addr  = addr;
        req_size  = size;
        req_burst = burst;
        req_valid = 1'b1;
        @(negedge clk);
        check(busy && ext_phase_hi, "R9", "busy after accept",
              64'({busy, ext_phase_hi}), 64'(2'b11));
        req_valid = poke;
        if (poke) begin
            req_addr  = addr ^ 32'h0012_3440;
            req_burst = 1'b1;
        end
        while (!done) @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(rd_data == exp && !done && req_ready, "R10", "read data held after done",
              rd_data, exp);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check(req_ready == 1'b1 && busy == 1'b0 && done == 1'b0, "R11", "reset flags",
              64'({req_ready, busy, done}), 64'(3'b100));
        check(ext_addr == '0 && rd_data == '0 &&
              !(ext_phase_hi || ext_phase_lo || ext_phase_data), "R11", "reset outputs",
              rd_data, 64'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // 32-bit bus
        run_access(32'h0000_1003, 2'd0, 1'b0, 2'd2, 1'b0);
        run_access(32'h0003_5006, 2'd1, 1'b0, 2'd2, 1'b0);
        run_access(32'h0ABC_DEF4, 2'd2, 1'b0, 2'd2, 1'b0);
        run_access(32'h2345_6788, 2'd3, 1'b0, 2'd2, 1'b0);
        run_access(32'h1357_9BD5, 2'd0, 1'b1, 2'd2, 1'b0);
        // reserved width code behaves as 32 bits
        run_access(32'h0246_8ACC, 2'd3, 1'b0, 2'd3, 1'b0);
        // 16-bit bus
        run_access(32'h0000_2001, 2'd0, 1'b0, 2'd1, 1'b0);
        run_access(32'h0765_4322, 2'd1, 1'b0, 2'd1, 1'b0);
        run_access(32'h0FED_CBA4, 2'd2, 1'b0, 2'd1, 1'b0);
        run_access(32'h0A5A_5A58, 2'd3, 1'b0, 2'd1, 1'b0);
        run_access(32'h0123_4563, 2'd1, 1'b1, 2'd1, 1'b0);
        // 8-bit bus
        run_access(32'h0000_0007, 2'd0, 1'b0, 2'd0, 1'b0);
        run_access(32'h05F0_0F0C, 2'd2, 1'b0, 2'd0, 1'b0);
        run_access(32'h0FFF_FFF8, 2'd3, 1'b0, 2'd0, 1'b0);
        run_access(32'h0080_1232, 2'd1, 1'b1, 2'd0, 1'b0);
        // requests held during busy are ignored
        run_access(32'h0111_2220, 2'd3, 1'b0, 2'd1, 1'b1);
        run_access(32'h0033_4444, 2'd2, 1'b0, 2'd0, 1'b1);

        repeat (3) @(negedge clk);
        check(q_hi.size() == 0 && q_lo.size() == 0 && q_data.size() == 0, "R9",
              "no leftover expected items", 64'(q_data.size()), 64'(0));
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog: actual no completion expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule